// File: doc/BRIEF.md
# AUX-Snoop DisplayPort Lane Steering

This block sets which of four DisplayPort lanes are powered and how the AUX differential pair is switched onto the two sideband pins. It monitors AUX write transactions that are already decoded. Each transaction arrives as a valid strobe, a 20-bit DPCD address and a data byte. From these the block captures two values: the sink's link power state and the trained lane count. Both values are held as hardware-updated status and drive the lane enables directly. Lanes that the link does not use stay unpowered.

Software can take over lane control. When it sets the snoop-off input, a per-lane disable vector decides the lanes instead. The connector mode select then masks the result: all lanes in four-lane DP mode, the lower half in the shared USB-plus-DP mode, and none otherwise. A two-bit route override either forces the AUX switch position or lets it follow the DP mode bit and the cable flip. When the DP bit of the mode select drops, both captured values clear, so a re-plugged link starts from a clean state.

Top module: `dp_lane_steer`

## Requirements
- R1: After reset, `powerState` and `laneCount` are 0, and `laneEn` is 4'b0000 while snoop is in use.
- R2: A clock edge with `snoopValid` high and `snoopAddr` equal to 20'h00600 loads `snoopData[1:0]` into `powerState`. The new value is visible after that edge.
- R3: A clock edge with `snoopValid` high and `snoopAddr` equal to 20'h00101 loads `snoopData[4:0]` into `laneCount`.
- R4: Both status values keep their contents when `snoopValid` is low, or when the address matches neither location.
- R5: With `snoopOff` low and `powerState` equal to 1, a `laneCount` of 1, 2 or 4 gives the base lane vector 4'b0001, 4'b0011 or 4'b1111. Any other count, or any other power state (2 included), gives 4'b0000.
- R6: With `snoopOff` high, base lane i is enabled exactly when `laneOff[i]` is 0. With `snoopOff` low, `laneOff` has no effect.
- R7: `laneEn` is the base vector ANDed with a mode mask. The mask is 4'b1111 for `modeSel`=2, 4'b0011 for `modeSel`=3, and 4'b0000 for `modeSel`=0 or 1.
- R8: On the edge after which `modeSel[1]` has gone from 1 to 0, both status values become 0. This clear wins over a snooped write on the same edge.
- R9: `auxSw` bits are {AUXN-SBU1, AUXP-SBU2, AUXN-SBU2, AUXP-SBU1}. The route override 1 gives 4'b0011, 2 gives 4'b1100, and 3 gives 4'b0000.
- R10: With the route override at 0, `auxSw` is 4'b0000 when `modeSel[1]` is 0. Otherwise it is 4'b0011 when `flipSel` is 0 and 4'b1100 when `flipSel` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| snoopValid | input | 1 | Decoded AUX write present this cycle |
| snoopAddr | input | 20 | DPCD address of the write |
| snoopData | input | 8 | Data byte of the write |
| modeSel | input | 2 | Connector mode: 0 off, 1 USB, 2 four-lane DP, 3 USB plus two DP lanes |
| flipSel | input | 1 | Cable orientation, 1 = flipped |
| auxRouteOvr | input | 2 | AUX switch override: 0 auto, 1 straight, 2 crossed, 3 open |
| snoopOff | input | 1 | 1 = lanes from `laneOff`, 0 = lanes from snooped values |
| laneOff | input | 4 | Per-lane disable used when snoop is off |
| laneEn | output | 4 | Lane power enables |
| auxSw | output | 4 | AUX-to-sideband switch closures |
| powerState | output | 2 | Captured link power state |
| laneCount | output | 5 | Captured lane count |

## Verification
The bench writes every power state, and for each one every one of the 32 lane-count values. This shows that legal counts separate from illegal ones, and that only the powered-on state lets a count through. It sweeps all 16 disable vectors under each mode, which separates the register-driven path from the mode mask. It drives all 32 combinations of route override, mode and flip, which separates forced routing from automatic routing. Mode sequences separate a falling DP bit from a rising one and from a change that keeps the bit. Near-miss addresses and strobe-low writes show that status is held.

// File: rtl/dpls_pkg.sv
package dpls_pkg;
  localparam logic [1:0] MODE_OFF = 2'd0;
  localparam logic [1:0] MODE_USB = 2'd1;
  localparam logic [1:0] MODE_DP4 = 2'd2;
  localparam logic [1:0] MODE_MIX = 2'd3;

  localparam logic [1:0] PWR_ON = 2'd1;

  localparam logic [1:0] ROUTE_AUTO     = 2'd0;
  localparam logic [1:0] ROUTE_STRAIGHT = 2'd1;
  localparam logic [1:0] ROUTE_CROSSED  = 2'd2;
  localparam logic [1:0] ROUTE_OPEN     = 2'd3;

  // switch bits: {N-SBU1, P-SBU2, N-SBU2, P-SBU1}
  localparam logic [3:0] SW_STRAIGHT = 4'b0011;
  localparam logic [3:0] SW_CROSSED  = 4'b1100;
  localparam logic [3:0] SW_OPEN     = 4'b0000;

  typedef struct packed {
    logic capPwr;
    logic capCnt;
    logic clr;
  } snoopStrb_t;
endpackage

// File: rtl/dpls_ctrl.sv
module dpls_ctrl
  import dpls_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter logic [ADDR_W-1:0] PWR_ADDR = 20'h00600,
  parameter logic [ADDR_W-1:0] CNT_ADDR = 20'h00101
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              snoopValid,
  input  logic [ADDR_W-1:0] snoopAddr,
  input  logic              modeDpBit,
  output snoopStrb_t        strb
);
  logic prevDpBit;
  logic dpFall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevDpBit <= 1'b0;
    else       prevDpBit <= modeDpBit;
  end

  // falling DP bit clears status and blocks a capture on the same edge
  always_comb begin
    dpFall      = prevDpBit & ~modeDpBit;
    strb.clr    = dpFall;
    strb.capPwr = snoopValid && (snoopAddr == PWR_ADDR) && !dpFall;
    strb.capCnt = snoopValid && (snoopAddr == CNT_ADDR) && !dpFall;
  end
endmodule

// File: rtl/dpls_data.sv
module dpls_data
  import dpls_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  snoopStrb_t        strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [1:0]        modeSel,
  input  logic              flipSel,
  input  logic [1:0]        auxRouteOvr,
  input  logic              snoopOff,
  input  logic [LANES-1:0]  laneOff,
  output logic [LANES-1:0]  laneEn,
  output logic [3:0]        auxSw,
  output logic [1:0]        powerState,
  output logic [CNT_W-1:0]  laneCount
);
  localparam int HALF = LANES / 2;

  logic             unusedDataBits;
  logic             cntLegal;
  logic [LANES-1:0] cntLanes;
  logic [LANES-1:0] modeMask;
  logic [LANES-1:0] snoopLanes;
  logic [LANES-1:0] baseLanes;

  assign unusedDataBits = ^wrData[DATA_W-1:CNT_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      powerState <= '0;
      laneCount  <= '0;
    end else if (strb.clr) begin
      powerState <= '0;
      laneCount  <= '0;
    end else begin
      if (strb.capPwr) powerState <= wrData[1:0];
      if (strb.capCnt) laneCount  <= wrData[CNT_W-1:0];
    end
  end

  // a count is usable when it is a nonzero power of two within the lane budget
  assign cntLegal = (laneCount != '0)
                 && ((laneCount & (laneCount - CNT_W'(1))) == '0)
                 && (laneCount <= CNT_W'(LANES));

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign cntLanes[i] = cntLegal && (CNT_W'(i) < laneCount);
    assign modeMask[i] = (modeSel == MODE_DP4)
                      || ((modeSel == MODE_MIX) && (i < HALF));
  end

  assign snoopLanes = (powerState == PWR_ON) ? cntLanes : '0;
  assign baseLanes  = snoopOff ? ~laneOff : snoopLanes;
  assign laneEn     = baseLanes & modeMask;

  always_comb begin
    case (auxRouteOvr)
      ROUTE_STRAIGHT: auxSw = SW_STRAIGHT;
      ROUTE_CROSSED:  auxSw = SW_CROSSED;
      ROUTE_OPEN:     auxSw = SW_OPEN;
      default:        auxSw = !modeSel[1] ? SW_OPEN
                            : (flipSel ? SW_CROSSED : SW_STRAIGHT);
    endcase
  end
endmodule

// File: rtl/dp_lane_steer.sv
module dp_lane_steer
  import dpls_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 5,
  parameter logic [ADDR_W-1:0] PWR_ADDR = 20'h00600,
  parameter logic [ADDR_W-1:0] CNT_ADDR = 20'h00101
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              snoopValid,
  input  logic [ADDR_W-1:0] snoopAddr,
  input  logic [DATA_W-1:0] snoopData,
  input  logic [1:0]        modeSel,
  input  logic              flipSel,
  input  logic [1:0]        auxRouteOvr,
  input  logic              snoopOff,
  input  logic [LANES-1:0]  laneOff,
  output logic [LANES-1:0]  laneEn,
  output logic [3:0]        auxSw,
  output logic [1:0]        powerState,
  output logic [CNT_W-1:0]  laneCount
);
  snoopStrb_t strb;

  dpls_ctrl #(.ADDR_W(ADDR_W), .PWR_ADDR(PWR_ADDR), .CNT_ADDR(CNT_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .snoopValid(snoopValid), .snoopAddr(snoopAddr),
    .modeDpBit(modeSel[1]), .strb(strb)
  );

  dpls_data #(.LANES(LANES), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(snoopData),
    .modeSel(modeSel), .flipSel(flipSel), .auxRouteOvr(auxRouteOvr),
    .snoopOff(snoopOff), .laneOff(laneOff), .laneEn(laneEn), .auxSw(auxSw),
    .powerState(powerState), .laneCount(laneCount)
  );
endmodule

// File: rtl/dpls_chk.sv
module dpls_chk #(
  parameter int LANES  = 4,
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 5,
  parameter logic [ADDR_W-1:0] PWR_ADDR = 20'h00600,
  parameter logic [ADDR_W-1:0] CNT_ADDR = 20'h00101
) (
  input logic              clk,
  input logic              rstN,
  input logic              snoopValid,
  input logic [ADDR_W-1:0] snoopAddr,
  input logic [DATA_W-1:0] snoopData,
  input logic [1:0]        modeSel,
  input logic              flipSel,
  input logic [1:0]        auxRouteOvr,
  input logic              snoopOff,
  input logic [LANES-1:0]  laneOff,
  input logic [LANES-1:0]  laneEn,
  input logic [3:0]        auxSw,
  input logic [1:0]        powerState,
  input logic [CNT_W-1:0]  laneCount
);
  logic seenDp;
  logic falling;
  logic hitAny;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) seenDp <= 1'b0;
    else       seenDp <= modeSel[1];
  end
  assign falling = seenDp && !modeSel[1];
  assign hitAny  = snoopValid && (snoopAddr == PWR_ADDR || snoopAddr == CNT_ADDR);

  p_cap_pwr_r2: assert property (@(posedge clk) disable iff (!rstN)
    (snoopValid && snoopAddr == PWR_ADDR && !falling) |=> powerState == $past(snoopData[1:0]));

  p_cap_cnt_r3: assert property (@(posedge clk) disable iff (!rstN)
    (snoopValid && snoopAddr == CNT_ADDR && !falling) |=> laneCount == $past(snoopData[CNT_W-1:0]));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!hitAny && !falling) |=> ($stable(powerState) && $stable(laneCount)));

  p_sleep_off_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!snoopOff && powerState != 2'd1) |-> laneEn == '0);

  p_mode_mask_r7: assert property (@(posedge clk) disable iff (!rstN)
    !modeSel[1] |-> laneEn == '0);

  p_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    falling |=> (powerState == 2'd0 && laneCount == '0));

  p_forced_route_r9: assert property (@(posedge clk) disable iff (!rstN)
    auxRouteOvr == 2'd3 |-> auxSw == 4'b0000);

  p_auto_route_r10: assert property (@(posedge clk) disable iff (!rstN)
    (auxRouteOvr == 2'd0 && !modeSel[1]) |-> auxSw == 4'b0000);
endmodule

bind dp_lane_steer dpls_chk #(
  .LANES(LANES), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
  .PWR_ADDR(PWR_ADDR), .CNT_ADDR(CNT_ADDR)
) u_chk (
  .clk(clk), .rstN(rstN), .snoopValid(snoopValid), .snoopAddr(snoopAddr),
  .snoopData(snoopData), .modeSel(modeSel), .flipSel(flipSel),
  .auxRouteOvr(auxRouteOvr), .snoopOff(snoopOff), .laneOff(laneOff),
  .laneEn(laneEn), .auxSw(auxSw), .powerState(powerState), .laneCount(laneCount)
);

// File: tb/sim_dp_lane_steer.sv
`timescale 1ns/1ps
module sim_dp_lane_steer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        snoopValid = 1'b0;
  logic [19:0] snoopAddr = '0;
  logic [7:0]  snoopData = '0;
  logic [1:0]  modeSel = 2'd2;
  logic        flipSel = 1'b0;
  logic [1:0]  auxRouteOvr = 2'd0;
  logic        snoopOff = 1'b0;
  logic [3:0]  laneOff = '0;
  logic [3:0]  laneEn;
  logic [3:0]  auxSw;
  logic [1:0]  powerState;
  logic [4:0]  laneCount;

  int checkCnt = 0;
  int failCnt  = 0;
  logic [1:0] mPwr = '0;
  logic [4:0] mCnt = '0;

  always #10 clk = ~clk;

  dp_lane_steer u0 (
    .clk(clk), .rstN(rstN), .snoopValid(snoopValid), .snoopAddr(snoopAddr),
    .snoopData(snoopData), .modeSel(modeSel), .flipSel(flipSel),
    .auxRouteOvr(auxRouteOvr), .snoopOff(snoopOff), .laneOff(laneOff),
    .laneEn(laneEn), .auxSw(auxSw), .powerState(powerState), .laneCount(laneCount)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] expLanes(logic [1:0] p, logic [4:0] c, logic off,
                                          logic [3:0] lo, logic [1:0] m);
    logic [3:0] b;
    logic [3:0] mask;
    if (off) b = ~lo;
    else if (p != 2'd1) b = 4'b0000;
    else b = (c == 5'd1) ? 4'b0001 : (c == 5'd2) ? 4'b0011 : (c == 5'd4) ? 4'b1111 : 4'b0000;
    mask = (m == 2'd2) ? 4'b1111 : (m == 2'd3) ? 4'b0011 : 4'b0000;
    return b & mask;
  endfunction

  function automatic logic [3:0] expAux(logic [1:0] o, logic [1:0] m, logic f);
    case (o)
      2'd1: return 4'b0011;
      2'd2: return 4'b1100;
      2'd3: return 4'b0000;
      default: return !m[1] ? 4'b0000 : (f ? 4'b1100 : 4'b0011);
    endcase
  endfunction

  task automatic snoopWr(input logic [19:0] a, input logic [7:0] d, input logic v);
    @(negedge clk);
    snoopValid = v; snoopAddr = a; snoopData = d;
    @(negedge clk);
    snoopValid = 1'b0;
    if (v && a == 20'h00600) mPwr = d[1:0];
    if (v && a == 20'h00101) mCnt = d[4:0];
    #1;
  endtask

  task automatic setMode(input logic [1:0] m);
    logic [1:0] old;
    @(negedge clk);
    old = modeSel;
    modeSel = m;
    @(negedge clk);
    if (old[1] && !m[1]) begin mPwr = '0; mCnt = '0; end
    #1;
  endtask

  task automatic chkAll(input string req);
    chk({req, " powerState"}, 32'(powerState), 32'(mPwr));
    chk({req, " laneCount"}, 32'(laneCount), 32'(mCnt));
    chk({req, " laneEn"}, 32'(laneEn), 32'(expLanes(mPwr, mCnt, snoopOff, laneOff, modeSel)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failCnt++; checkCnt++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    chk("R1 powerState", 32'(powerState), 0);
    chk("R1 laneCount", 32'(laneCount), 0);
    chk("R1 laneEn", 32'(laneEn), 0);

    // R2 R3 R5: every power state with every count, four-lane mode
    for (int p = 0; p < 4; p++) begin
      snoopWr(20'h00600, 8'(p) | 8'hFC, 1'b1);
      chk("R2 powerState", 32'(powerState), 32'(p));
      for (int c = 0; c < 32; c++) begin
        snoopWr(20'h00101, 8'(c) | 8'hE0, 1'b1);
        chk("R3 laneCount", 32'(laneCount), 32'(c));
        chk("R5 laneEn", 32'(laneEn), 32'(expLanes(mPwr, mCnt, 1'b0, 4'h0, 2'd2)));
      end
    end

    // R4 ignored writes
    snoopWr(20'h00600, 8'h01, 1'b1);
    snoopWr(20'h00101, 8'h02, 1'b1);
    snoopWr(20'h00600, 8'h02, 1'b0);
    chkAll("R4 strobe low pwr");
    snoopWr(20'h00101, 8'h04, 1'b0);
    chkAll("R4 strobe low cnt");
    snoopWr(20'h00601, 8'h02, 1'b1);
    chkAll("R4 addr 601");
    snoopWr(20'h10600, 8'h02, 1'b1);
    chkAll("R4 addr 10600");
    snoopWr(20'h00100, 8'h04, 1'b1);
    chkAll("R4 addr 100");
    snoopWr(20'h00102, 8'h04, 1'b1);
    chkAll("R4 addr 102");
    chk("R4 laneEn", 32'(laneEn), 32'h3);

    // R6 laneOff ignored while snooping
    snoopWr(20'h00101, 8'h04, 1'b1);
    for (int lo = 0; lo < 16; lo++) begin
      laneOff = 4'(lo); #1;
      chk("R6 laneOff no effect", 32'(laneEn), 32'hF);
    end

    // R7 mode mask on snooped lanes
    setMode(2'd3); chkAll("R7 mode3");
    chk("R7 mode3 half", 32'(laneEn), 32'h3);
    setMode(2'd2); chkAll("R7 mode2");

    // R6 R7 register-driven lanes across modes
    snoopOff = 1'b1;
    for (int m = 0; m < 4; m++) begin
      setMode(2'(m));
      for (int lo = 0; lo < 16; lo++) begin
        laneOff = 4'(lo); #1;
        chk("R6 R7 laneEn", 32'(laneEn), 32'(expLanes(mPwr, mCnt, 1'b1, 4'(lo), 2'(m))));
      end
    end
    snoopOff = 1'b0; laneOff = '0;

    // R8 clearing on falling DP bit
    setMode(2'd2);
    snoopWr(20'h00600, 8'h01, 1'b1); snoopWr(20'h00101, 8'h04, 1'b1);
    setMode(2'd0);
    chk("R8 2to0 pwr", 32'(powerState), 0);
    chk("R8 2to0 cnt", 32'(laneCount), 0);
    setMode(2'd3);
    snoopWr(20'h00600, 8'h01, 1'b1); snoopWr(20'h00101, 8'h02, 1'b1);
    setMode(2'd1);
    chk("R8 3to1 pwr", 32'(powerState), 0);
    chk("R8 3to1 cnt", 32'(laneCount), 0);
    snoopWr(20'h00600, 8'h01, 1'b1); snoopWr(20'h00101, 8'h04, 1'b1);
    chkAll("R8 capture in mode1");
    setMode(2'd2);
    chkAll("R8 rise keeps");
    chk("R8 rise lanes", 32'(laneEn), 32'hF);
    setMode(2'd3);
    chkAll("R8 bit held keeps");
    setMode(2'd2);
    @(negedge clk);
    modeSel = 2'd0; snoopValid = 1'b1; snoopAddr = 20'h00600; snoopData = 8'h02;
    @(negedge clk);
    snoopValid = 1'b0; #1;
    chk("R8 clear beats capture", 32'(powerState), 0);
    mPwr = '0; mCnt = '0;

    // R9 R10 routing sweep
    for (int o = 0; o < 4; o++)
      for (int m = 0; m < 4; m++)
        for (int f = 0; f < 2; f++) begin
          auxRouteOvr = 2'(o); flipSel = 1'(f);
          setMode(2'(m));
          chk(o == 0 ? "R10 auxSw" : "R9 auxSw", 32'(auxSw), 32'(expAux(2'(o), 2'(m), 1'(f))));
        end

    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end
endmodule